// File: doc/BRIEF.md
# Double-Buffered Serial Transmit Register

This block is the last digital stage of a packet radio transmitter. A host hands it bytes through a one-cycle write strobe. The block turns them into a serial modulation bit that moves forward once per bit-rate tick. There are two byte slots in series. The shifter holds the byte now on the air, and the holding slot keeps the next one, so the host has a whole byte time to supply fresh data. A request flag shows whether the holding slot can take a byte. A write that arrives while the slot is still occupied is thrown away and latches an overwrite error.

Both slots start out holding an alternating 1,0 pattern. When the host has nothing queued, the block sends a preamble instead of stale data. Dropping the transmit enable restores that pattern in both slots. When buffering is turned off, the modulation bit is taken straight from an external data pin. A polarity input XORs every outgoing bit, so the deviation sign can be swapped without touching the data.

Top module: `txdb_serializer`

## Requirements
- R1: After reset the request flag is 1, the overwrite error is 0, and with buffering on and polarity 0 the modulation bit is 1, the first bit of the preamble.
- R2: Both slots reset to the alternating pattern 0xAA (DW bits of 1,0 starting with 1). With no host writes, each tick sends 1,0,1,0,… without a break, across the slot boundary.
- R3: While transmit enable and buffer enable are both 1, each bit-rate tick advances the shifter by one bit, MSB first. The modulation bit shows the shifter's current MSB and changes in the cycle after the tick.
- R4: A write while the request flag is 1 stores the byte in the holding slot and clears the request flag in the next cycle. That byte is sent right after the byte now in the shifter.
- R5: In the cycle after the tick that sends the last bit of a byte, the holding slot moves into the shifter, the holding slot reloads 0xAA, and the request flag returns to 1.
- R6: A write while the request flag is 0 leaves the holding slot unchanged and sets a sticky overwrite error flag.
- R7: A 1-to-0 change of transmit enable reloads both slots with 0xAA, restarts the bit count, and clears the overwrite error. The request flag is 1 in the next cycle.
- R8: While transmit enable is 0, a write is stored and no bits advance. Once transmit enable goes to 1, one preamble byte goes out, then the stored byte.
- R9: With buffer enable 0, the modulation bit equals the external data pin XOR polarity, and the slots do not advance on ticks.
- R10: With polarity 1, the modulation bit is the inverse of the bit that would be sent with polarity 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en | input | 1 | Transmit enable; a falling edge reloads the preamble |
| buf_en | input | 1 | 1: bits come from the slots; 0: bits come from the external pin |
| wr_stb | input | 1 | One-cycle byte write strobe |
| wr_data | input | DW | Byte to queue |
| bit_tick | input | 1 | One-cycle bit-rate tick |
| ext_bit | input | 1 | External modulation data pin |
| pol | input | 1 | Output polarity; 1 inverts the modulation bit |
| mod_bit | output | 1 | Serial modulation bit |
| byte_req | output | 1 | Holding slot free; the host may write |
| ovr_err | output | 1 | Sticky: a write came while byte_req was 0 |

## Verification
Directed sequences come first. One checks the untouched preamble over sixteen ticks, which shows whether the handoff between slots breaks the pattern. One queues a byte while transmit is disabled, then adds an extra write on top of it; this separates an accepted write from a rejected one, and shows whether the queued byte keeps its place after one preamble byte. Others cover bypass and inverted polarity, which check output source selection separately from shifting. After that, a long seeded random run varies the tick rate, write timing, enable drops, bypass and polarity against a behavioural model. That run reaches the cases where a write and a byte handoff fall in the same cycle, and where an enable drop lands partway through a byte.

// File: rtl/txdb_pkg.sv
package txdb_pkg;
   parameter int unsigned TXDB_DW_DEF = 8;

   typedef enum logic {
      SRC_PIN = 1'b0,
      SRC_REG = 1'b1
   } txdb_src_e;
endpackage

// File: rtl/txdb_hold.sv
module txdb_hold #(
   parameter int unsigned DW = 8,
   parameter logic [DW-1:0] PRE = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reinit,
   input  logic          wr_stb,
   input  logic [DW-1:0] wr_data,
   input  logic          take,
   output logic [DW-1:0] hold_q,
   output logic          full,
   output logic          ovr_err
);
   logic accept, reject;

   assign accept = wr_stb & ~full;
   assign reject = wr_stb & full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q  <= PRE;
         full    <= 1'b0;
         ovr_err <= 1'b0;
      end else if (reinit) begin
         hold_q  <= PRE;
         full    <= 1'b0;
         ovr_err <= 1'b0;
      end else begin
         if (accept) begin
            hold_q <= wr_data;
            full   <= 1'b1;
         end else if (take) begin
            hold_q <= PRE;
            full   <= 1'b0;
         end
         if (reject) ovr_err <= 1'b1;
      end
   end

   AST_ACCEPT_STORES: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && !full && !reinit) |=> (full && hold_q == $past(wr_data))); // R4
   AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && full && !take && !reinit) |=> ($stable(hold_q) && ovr_err)); // R6
   AST_EMPTY_IS_PRE: assert property (@(posedge clk) disable iff (!rst_n)
      !full |-> hold_q == PRE); // R2
   AST_REINIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      reinit |=> (!full && !ovr_err && hold_q == PRE)); // R7
endmodule

// File: rtl/txdb_shift.sv
module txdb_shift #(
   parameter int unsigned DW = 8,
   parameter logic [DW-1:0] PRE = '0,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reinit,
   input  logic          adv,
   input  logic [DW-1:0] load_val,
   output logic          cur_bit,
   output logic          take
);
   localparam int unsigned CW = (DW > 2) ? $clog2(DW) : 1;
   localparam logic [CW-1:0] LAST = CW'(DW - 1);

   logic [DW-1:0] sh;
   logic [DW-1:0] sh_next;
   logic [CW-1:0] cnt;

   assign take = adv & (cnt == LAST);

   generate
      if (MSB_FIRST) begin : g_msb
         assign cur_bit = sh[DW-1];
         assign sh_next = {sh[DW-2:0], 1'b0};
         AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
            (adv && !take && !reinit) |=> sh[DW-1:1] == $past(sh[DW-2:0])); // R3
      end else begin : g_lsb
         assign cur_bit = sh[0];
         assign sh_next = {1'b0, sh[DW-1:1]};
         AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
            (adv && !take && !reinit) |=> sh[DW-2:0] == $past(sh[DW-1:1])); // R3
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh  <= PRE;
         cnt <= '0;
      end else if (reinit) begin
         sh  <= PRE;
         cnt <= '0;
      end else if (adv) begin
         if (take) begin
            sh  <= load_val;
            cnt <= '0;
         end else begin
            sh  <= sh_next;
            cnt <= cnt + 1'b1;
         end
      end
   end

   AST_TAKE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !reinit) |=> sh == $past(load_val)); // R5
   AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv && !reinit) |=> $stable(sh)); // R9
   AST_REINIT_SH: assert property (@(posedge clk) disable iff (!rst_n)
      reinit |=> (sh == PRE && cnt == '0)); // R7
endmodule

// File: rtl/txdb_outsel.sv
module txdb_outsel
   import txdb_pkg::*;
(
   input  logic buf_en,
   input  logic pol,
   input  logic reg_bit,
   input  logic ext_bit,
   output logic mod_bit
);
   txdb_src_e src;
   logic      raw;

   assign src = buf_en ? SRC_REG : SRC_PIN;

   always_comb begin
      case (src)
         SRC_REG: raw = reg_bit;
         default: raw = ext_bit;
      endcase
   end

   assign mod_bit = raw ^ pol;
endmodule

// File: rtl/txdb_serializer.sv
module txdb_serializer #(
   parameter int unsigned DW = txdb_pkg::TXDB_DW_DEF,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tx_en,
   input  logic          buf_en,
   input  logic          wr_stb,
   input  logic [DW-1:0] wr_data,
   input  logic          bit_tick,
   input  logic          ext_bit,
   input  logic          pol,
   output logic          mod_bit,
   output logic          byte_req,
   output logic          ovr_err
);
   localparam logic [DW-1:0] PRE = {(DW/2){2'b10}};

   generate
      if (DW < 2 || (DW % 2) != 0) begin : g_bad_dw
         $error("txdb_serializer: DW must be even and at least 2");
      end
   endgenerate

   logic          en_q;
   logic          reinit;
   logic          adv;
   logic          take;
   logic          full;
   logic          cur_bit;
   logic [DW-1:0] hold_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_q <= 1'b0;
      else        en_q <= tx_en;
   end

   assign reinit   = en_q & ~tx_en;
   assign adv      = tx_en & buf_en & bit_tick;
   assign byte_req = ~full;

   txdb_hold #(.DW(DW), .PRE(PRE)) u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .reinit  (reinit),
      .wr_stb  (wr_stb),
      .wr_data (wr_data),
      .take    (take),
      .hold_q  (hold_q),
      .full    (full),
      .ovr_err (ovr_err)
   );

   txdb_shift #(.DW(DW), .PRE(PRE), .MSB_FIRST(MSB_FIRST)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .reinit   (reinit),
      .adv      (adv),
      .load_val (hold_q),
      .cur_bit  (cur_bit),
      .take     (take)
   );

   txdb_outsel u_out (
      .buf_en  (buf_en),
      .pol     (pol),
      .reg_bit (cur_bit),
      .ext_bit (ext_bit),
      .mod_bit (mod_bit)
   );

   AST_REQ_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && byte_req && !reinit) |=> !byte_req); // R4
   AST_REQ_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !wr_stb && !reinit) |=> byte_req); // R5
   AST_REINIT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      reinit |=> (byte_req && !ovr_err)); // R7
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_err && tx_en) |=> ovr_err); // R6
endmodule

// File: tb/sim_txdb_serializer.sv
`timescale 1ns/1ps
module sim_txdb_serializer;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tx_en = 1'b0, buf_en = 1'b1, wr_stb = 1'b0, bit_tick = 1'b0;
   logic       ext_bit = 1'b0, pol = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       mod_bit, byte_req, ovr_err;

   int nvec = 0;
   int nerr = 0;

   logic [7:0] m_sh, m_hold;
   logic       m_full, m_err, m_enq;
   int         m_cnt;

   always #4 clk = ~clk;

   txdb_serializer u0 (
      .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .buf_en(buf_en),
      .wr_stb(wr_stb), .wr_data(wr_data), .bit_tick(bit_tick),
      .ext_bit(ext_bit), .pol(pol), .mod_bit(mod_bit),
      .byte_req(byte_req), .ovr_err(ovr_err)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      nvec++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic void m_reset();
      m_sh = 8'hAA; m_hold = 8'hAA; m_full = 1'b0; m_err = 1'b0;
      m_enq = 1'b0; m_cnt = 0;
   endfunction

   function automatic logic m_mod();
      return (buf_en ? m_sh[7] : ext_bit) ^ pol;
   endfunction

   function automatic void m_step();
      logic reinit, adv, take;
      reinit = m_enq && !tx_en;
      m_enq  = tx_en;
      if (reinit) begin
         m_sh = 8'hAA; m_hold = 8'hAA; m_full = 1'b0; m_err = 1'b0; m_cnt = 0;
      end else begin
         adv  = tx_en && buf_en && bit_tick;
         take = adv && (m_cnt == 7);
         if (take) begin
            m_sh = m_hold; m_cnt = 0;
         end else if (adv) begin
            m_sh = {m_sh[6:0], 1'b0}; m_cnt++;
         end
         if (wr_stb && !m_full) begin
            m_hold = wr_data; m_full = 1'b1;
         end else begin
            if (wr_stb) m_err = 1'b1;
            if (take) begin m_hold = 8'hAA; m_full = 1'b0; end
         end
      end
   endfunction

   task automatic apply(input logic en, input logic be, input logic tk,
                        input logic wr, input logic [7:0] d,
                        input logic ex, input logic pl);
      tx_en = en; buf_en = be; bit_tick = tk; wr_stb = wr; wr_data = d;
      ext_bit = ex; pol = pl;
      #1;
      chk(!buf_en ? "R9" : (pol ? "R10" : "R3"), {7'd0, mod_bit}, {7'd0, m_mod()});
      chk("R5", {7'd0, byte_req}, {7'd0, ~m_full});
      chk("R6", {7'd0, ovr_err}, {7'd0, m_err});
   endtask

   task automatic adv_clk();
      @(posedge clk);
      m_step();
      @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      m_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic run_all();
      logic [7:0] pat;
      // R1: reset state
      do_reset();
      apply(0, 1, 0, 0, 8'h00, 0, 0);
      chk("R1", {7'd0, byte_req}, 8'd1);
      chk("R1", {7'd0, ovr_err}, 8'd0);
      chk("R1", {7'd0, mod_bit}, 8'd1);
      adv_clk();

      // R2: sixteen ticks of untouched preamble, across the slot handoff
      for (int i = 0; i < 16; i++) begin
         apply(1, 1, 1, 0, 8'h00, 0, 0);
         chk("R2", {7'd0, mod_bit}, {7'd0, ~i[0]});
         adv_clk();
      end

      // R7: enable drop reloads preamble
      apply(1, 1, 1, 0, 8'h00, 0, 0); adv_clk();
      apply(0, 1, 0, 0, 8'h00, 0, 0); adv_clk();
      apply(0, 1, 0, 0, 8'h00, 0, 0);
      chk("R7", {7'd0, mod_bit}, 8'd1);
      chk("R7", {7'd0, byte_req}, 8'd1);
      adv_clk();

      // R8/R4: write while disabled, then enable
      pat = 8'h3C;
      apply(0, 1, 0, 1, pat, 0, 0); adv_clk();
      apply(0, 1, 1, 0, 8'h00, 0, 0);
      chk("R4", {7'd0, byte_req}, 8'd0);
      chk("R8", {7'd0, mod_bit}, 8'd1);
      adv_clk();
      for (int j = 0; j < 16; j++) begin
         // R6: extra write while slot full
         apply(1, 1, 1, (j == 2), 8'hFF, 0, 0);
         if (j < 8) begin
            chk("R8", {7'd0, mod_bit}, {7'd0, ~j[0]});
            chk("R4", {7'd0, byte_req}, 8'd0);
         end else begin
            chk("R8", {7'd0, mod_bit}, {7'd0, pat[15-j]});
            chk("R5", {7'd0, byte_req}, 8'd1);
         end
         if (j > 2) chk("R6", {7'd0, ovr_err}, 8'd1);
         adv_clk();
      end

      // R7: enable drop clears the error
      apply(0, 1, 0, 0, 8'h00, 0, 0); adv_clk();
      apply(0, 1, 0, 0, 8'h00, 0, 0);
      chk("R7", {7'd0, ovr_err}, 8'd0);
      adv_clk();

      // R9: bypass follows the pin, slots frozen
      for (int k = 0; k < 6; k++) begin
         apply(1, 0, 1, 0, 8'h00, k[0], 0);
         chk("R9", {7'd0, mod_bit}, {7'd0, k[0]});
         adv_clk();
      end
      apply(1, 1, 0, 0, 8'h00, 0, 0);
      chk("R9", {7'd0, mod_bit}, 8'd1);
      adv_clk();

      // R10: polarity inverts
      apply(1, 1, 0, 0, 8'h00, 0, 1);
      chk("R10", {7'd0, mod_bit}, 8'd0);
      adv_clk();
      apply(1, 0, 0, 0, 8'h00, 1, 1);
      chk("R10", {7'd0, mod_bit}, 8'd0);
      adv_clk();

      // random phase
      void'($urandom(32'h5EED_0042));
      for (int n = 0; n < 4000; n++) begin
         apply(($urandom_range(0, 99) != 0),
               ($urandom_range(0, 19) != 0),
               ($urandom_range(0, 2) == 0),
               ($urandom_range(0, 5) == 0),
               8'($urandom()),
               1'($urandom()),
               ($urandom_range(0, 9) == 0));
         adv_clk();
      end
   endtask

   initial begin
      fork
         run_all();
         begin
            #(200000 * 8);
            nvec++; nerr++;
            $display("FAIL watchdog expired actual=running expected=done");
         end
      join_any
      disable fork;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
   end
endmodule